// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Pointer

This block generates the address for a sequentially accessed memory. It covers a 13-bit space and holds two buffer regions, each described by a start address and an end address. Every clock edge that has the active-low count enable low moves the pointer one step. The way the pointer behaves when it reaches a buffer's end is chosen per buffer, from four modes held in a flow-control register.

End-of-buffer events are remembered in two sticky flag bits that can be read back. Two active-low outputs report those events to the outside, and a write-inhibit output is raised while the pointer is parked by stop mode.

Software or a sequencer drives the block through one command port (valid/ready, opcode plus data). A command can load the pointer, the start and end registers, the flow-control register, or clear flags. `cmd_ready` is tied high: the block takes one command on every clock edge where `cmd_valid` is high and never applies back-pressure. An edge that carries a command does not advance the pointer.

Top module: `dbp_seq_ptr`

## Requirements
- R1: After reset the address is 0x0000, both flags are 0, both end-of-buffer outputs are high, write inhibit is low, and both buffers are in linear mode.
- R2: `cmd_ready` is always 1. The opcodes are 0 no effect, 1 load pointer, 2 load start of buffer 1, 3 load end of buffer 1, 4 load start of buffer 2, 5 load end of buffer 2, 6 write flow control, 7 write flags. An edge with an accepted command never advances the pointer.
- R3: On an edge with `cnt_en_n` low, no command and no halt, the pointer advances by one and wraps from 0x1FFF to 0x0000.
- R4: When an advance makes the pointer equal to a buffer's end address, that buffer's flag (`flag_q[0]` for buffer 1, `flag_q[1]` for buffer 2) becomes 1 and stays 1 until it is cleared. A buffer's `eobN_n` is low whenever its flag is 1 and its mode is not mask.
- R5: Flow-control data bits [1:0] select buffer 1's mode and bits [3:2] select buffer 2's mode, with 00 chaining, 01 stop, 10 linear and 11 mask. In chaining mode, an advance from a buffer's end address loads the start address of the other buffer. If both buffers are at their end and both chain, the pointer goes to the start of buffer 1.
- R6: In stop mode, the first edge with the pointer at the end address halts it. If count enable is low on that edge the pointer halts at end+1; otherwise it halts at the end address. While halted, `wr_inhibit` is 1 and the pointer does not advance.
- R7: A flow-control write with data bit 4 at 0 releases a halted pointer only if count enable is low on the next edge. That edge advances the pointer by one (to end+2 after a halt at end+1). If count enable is high on that edge, the halt stays in force.
- R8: Loading the pointer or either start address clears a halt at once.
- R9: In linear mode the flag sets at the end address and the pointer keeps incrementing.
- R10: In mask mode the flag still sets but that buffer's `eobN_n` stays high, and the pointer keeps incrementing.
- R11: A flag write clears each flag whose data bit (bit 0 for buffer 1, bit 1 for buffer 2) is 0 and leaves each flag whose data bit is 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 13 | Command data (address or register bits) |
| cnt_en_n | input | 1 | Count enable, active low |
| addr | output | 13 | Current pointer |
| eob1_n | output | 1 | Buffer 1 end reached, active low |
| eob2_n | output | 1 | Buffer 2 end reached, active low |
| wr_inhibit | output | 1 | Pointer parked by stop mode |
| flag_q | output | 2 | Sticky end-of-buffer flags |

## Verification
The pointer, the flags and the halt state all change on the same rising edge that samples a command or a count enable. The end-of-buffer outputs follow the flags with no further delay, so every result is due one edge after its stimulus. The bench drives its inputs on falling edges and compares every output at the following falling edge against a cycle model written from the requirements. The two-edge stop release rule is checked with enable patterns that place the enabled edge both directly after the release write and one edge later.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int NBUF = 2;
  localparam int FLOW_REL_BIT = 4;

  typedef enum logic [1:0] {
    EOB_CHAIN  = 2'b00,
    EOB_STOP   = 2'b01,
    EOB_LINEAR = 2'b10,
    EOB_MASK   = 2'b11
  } eob_mode_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PTR    = 3'd1,
    OP_START1 = 3'd2,
    OP_END1   = 3'd3,
    OP_START2 = 3'd4,
    OP_END2   = 3'd5,
    OP_FLOW   = 3'd6,
    OP_FLAGS  = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/dbp_region.sv
// One buffer region: start/end registers plus end-address comparators.
module dbp_region #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start,
  input  logic          ld_end,
  input  logic [AW-1:0] din,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic          at_end,
  output logic          lands
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (ld_start) start_q <= din;
      if (ld_end)   end_q   <= din;
    end
  end

  assign at_end = (ptr == end_q);
  assign lands  = (nxt == end_q);
endmodule

// File: rtl/dbp_step.sv
// Next-pointer selection: chaining jumps, otherwise increment with wrap.
module dbp_step import dbp_pkg::*; #(
  parameter int AW = 13,
  parameter int NB = NBUF
) (
  input  logic [AW-1:0]          ptr,
  input  logic [NB-1:0][AW-1:0]  start_q,
  input  logic [NB-1:0]          at_end,
  input  logic [NB-1:0][1:0]     mode_q,
  output logic [AW-1:0]          nxt
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  // Higher buffer index wins, so two chaining buffers sharing an end
  // address send the pointer to the start of buffer 1.
  always_comb begin
    nxt = ptr + ONE;
    for (int i = 0; i < NB; i++) begin
      if (at_end[i] && (mode_q[i] == EOB_CHAIN))
        nxt = start_q[(i + 1) % NB];
    end
  end
endmodule

// File: rtl/dbp_halt_ctl.sv
// Stop-mode halt state and the two-edge release sequence.
module dbp_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_acc,
  input  logic clr,
  input  logic rel_req,
  input  logic cnt_en,
  input  logic stop_hit,
  output logic halted,
  output logic rel_pend,
  output logic adv
);
  assign adv = !cmd_acc && cnt_en && (!halted || rel_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted   <= 1'b0;
      rel_pend <= 1'b0;
    end else if (clr) begin
      halted   <= 1'b0;
      rel_pend <= 1'b0;
    end else if (cmd_acc) begin
      rel_pend <= rel_req && halted;
    end else begin
      rel_pend <= 1'b0;
      if (rel_pend && cnt_en)
        halted <= 1'b0;
      else if (!halted && stop_hit)
        halted <= 1'b1;
    end
  end
endmodule

// File: rtl/dbp_seq_ptr.sv
module dbp_seq_ptr import dbp_pkg::*; #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_data,
  input  logic          cnt_en_n,
  output logic [AW-1:0] addr,
  output logic          eob1_n,
  output logic          eob2_n,
  output logic          wr_inhibit,
  output logic [1:0]    flag_q
);
  localparam int NB = NBUF;

  cmd_op_e              op;
  logic                 cmd_acc;
  logic [AW-1:0]        ptr;
  logic [AW-1:0]        nxt;
  logic [NB-1:0]        flag_r;
  logic [NB-1:0][1:0]   mode_q;
  logic [NB-1:0]        ld_start, ld_end, at_end, lands, eob_n, stop_b;
  logic [NB-1:0][AW-1:0] start_q, end_q;
  logic                 clr, rel_req, halted, rel_pend, adv;

  assign cmd_ready = 1'b1;
  assign cmd_acc   = cmd_valid && cmd_ready;
  assign op        = cmd_op_e'(cmd_op);

  for (genvar g = 0; g < NB; g++) begin : g_buf
    localparam cmd_op_e START_OP = (g == 0) ? OP_START1 : OP_START2;
    localparam cmd_op_e END_OP   = (g == 0) ? OP_END1   : OP_END2;

    assign ld_start[g] = cmd_acc && (op == START_OP);
    assign ld_end[g]   = cmd_acc && (op == END_OP);

    dbp_region #(.AW(AW)) u_region (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_start (ld_start[g]),
      .ld_end   (ld_end[g]),
      .din      (cmd_data),
      .ptr      (ptr),
      .nxt      (nxt),
      .start_q  (start_q[g]),
      .end_q    (end_q[g]),
      .at_end   (at_end[g]),
      .lands    (lands[g])
    );

    assign stop_b[g] = at_end[g] && (mode_q[g] == EOB_STOP);
    assign eob_n[g]  = ~(flag_r[g] && (mode_q[g] != EOB_MASK));
  end

  dbp_step #(.AW(AW), .NB(NB)) u_step (
    .ptr     (ptr),
    .start_q (start_q),
    .at_end  (at_end),
    .mode_q  (mode_q),
    .nxt     (nxt)
  );

  assign clr     = cmd_acc && ((op == OP_PTR) || (|ld_start));
  assign rel_req = cmd_acc && (op == OP_FLOW) && !cmd_data[FLOW_REL_BIT];

  dbp_halt_ctl u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_acc  (cmd_acc),
    .clr      (clr),
    .rel_req  (rel_req),
    .cnt_en   (!cnt_en_n),
    .stop_hit (|stop_b),
    .halted   (halted),
    .rel_pend (rel_pend),
    .adv      (adv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mode_q[i] <= EOB_LINEAR;
    end else if (cmd_acc && (op == OP_FLOW)) begin
      mode_q <= cmd_data[2*NB-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      flag_r <= '0;
    end else begin
      if (cmd_acc && (op == OP_PTR)) ptr <= cmd_data;
      else if (adv)                  ptr <= nxt;

      if (cmd_acc && (op == OP_FLAGS)) flag_r <= flag_r & cmd_data[NB-1:0];
      else if (adv)                    flag_r <= flag_r | lands;
    end
  end

  assign addr       = ptr;
  assign eob1_n     = eob_n[0];
  assign eob2_n     = eob_n[1];
  assign wr_inhibit = halted;
  assign flag_q     = flag_r;
endmodule

// File: rtl/dbp_ptr_chk.sv
module dbp_ptr_chk #(
  parameter int AW = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2:0]         cmd_op,
  input logic [AW-1:0]      cmd_data,
  input logic               cnt_en_n,
  input logic [AW-1:0]      addr,
  input logic               eob1_n,
  input logic               eob2_n,
  input logic               wr_inhibit,
  input logic [1:0]         flag_q,
  input logic               rel_pend,
  input logic [1:0][1:0]    mode_q,
  input logic [1:0][AW-1:0] end_q
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  logic [1:0] eob_n;
  assign eob_n = {eob2_n, eob1_n};

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_n && !cmd_valid && !wr_inhibit && addr != end_q[0] && addr != end_q[1])
    |=> (addr == $past(addr) + ONE));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && !cmd_valid && !rel_pend) |=> ($stable(addr) && wr_inhibit));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> (addr == $past(cmd_data) && !wr_inhibit));

  for (genvar i = 0; i < 2; i++) begin : g_b
    p_eob_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !eob_n[i] |-> flag_q[i]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !cmd_valid) |=> flag_q[i]);
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == 2'b11) |-> eob_n[i]);
  end
endmodule

bind dbp_seq_ptr dbp_ptr_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_data   (cmd_data),
  .cnt_en_n   (cnt_en_n),
  .addr       (addr),
  .eob1_n     (eob1_n),
  .eob2_n     (eob2_n),
  .wr_inhibit (wr_inhibit),
  .flag_q     (flag_q),
  .rel_pend   (rel_pend),
  .mode_q     (mode_q),
  .end_q      (end_q)
);

// File: tb/dbp_seq_ptr_test.sv
module dbp_seq_ptr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [12:0] cmd_data = '0;
  logic        cnt_en_n = 1'b1;
  logic [12:0] addr;
  logic        eob1_n, eob2_n, wr_inhibit;
  logic [1:0]  flag_q;

  int checks = 0;
  int fails = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  dbp_seq_ptr uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cnt_en_n(cnt_en_n), .addr(addr),
    .eob1_n(eob1_n), .eob2_n(eob2_n), .wr_inhibit(wr_inhibit), .flag_q(flag_q)
  );

  // Cycle model built from the requirements.
  logic [12:0] m_ptr, m_s1, m_e1, m_s2, m_e2;
  logic [1:0]  m_m1, m_m2, m_fl;
  bit          m_halt, m_rel;

  always @(posedge clk or negedge rst_n) begin
    logic [12:0] nx;
    bit stp, trig, rel_n;
    if (!rst_n) begin
      m_ptr = 0; m_s1 = 0; m_e1 = 0; m_s2 = 0; m_e2 = 0;
      m_m1 = 2'b10; m_m2 = 2'b10; m_fl = 0; m_halt = 0; m_rel = 0;
    end else begin
      rel_n = 0;
      if (cmd_valid) begin
        case (cmd_op)
          3'd1: begin m_ptr = cmd_data; m_halt = 0; end
          3'd2: begin m_s1 = cmd_data; m_halt = 0; end
          3'd3: m_e1 = cmd_data;
          3'd4: begin m_s2 = cmd_data; m_halt = 0; end
          3'd5: m_e2 = cmd_data;
          3'd6: begin
            m_m1 = cmd_data[1:0]; m_m2 = cmd_data[3:2];
            rel_n = !cmd_data[4] && m_halt;
          end
          3'd7: m_fl = m_fl & cmd_data[1:0];
          default: ;
        endcase
      end else begin
        stp  = !cnt_en_n && (!m_halt || m_rel);
        trig = !m_halt && ((m_ptr == m_e1 && m_m1 == 2'b01) || (m_ptr == m_e2 && m_m2 == 2'b01));
        if (m_ptr == m_e2 && m_m2 == 2'b00)      nx = m_s1;
        else if (m_ptr == m_e1 && m_m1 == 2'b00) nx = m_s2;
        else                                     nx = m_ptr + 13'd1;
        if (stp) begin
          m_ptr = nx;
          m_fl  = m_fl | {nx == m_e2, nx == m_e1};
          if (m_rel) m_halt = 0;
        end
        if (trig) m_halt = 1;
      end
      m_rel = rel_n;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(cur_tag, "addr", int'(addr), int'(m_ptr));
      chk(cur_tag, "eob1_n", int'(eob1_n), int'(!(m_fl[0] && m_m1 != 2'b11)));
      chk(cur_tag, "eob2_n", int'(eob2_n), int'(!(m_fl[1] && m_m2 != 2'b11)));
      chk(cur_tag, "wr_inhibit", int'(wr_inhibit), int'(m_halt));
      chk(cur_tag, "flag_q", int'(flag_q), int'(m_fl));
    end
  end

  task automatic cmd(logic [2:0] op, logic [12:0] d, bit en = 0);
    cmd_valid = 1; cmd_op = op; cmd_data = d; cnt_en_n = !en;
    @(negedge clk);
    cmd_valid = 0; cnt_en_n = 1;
  endtask

  function automatic bit en_at(int i, int pat);
    case (pat)
      0: return 1'b1;
      1: return (i % 2) == 0;
      default: return (i % 3) != 2;
    endcase
  endfunction

  task automatic run(int n, int pat = 0);
    for (int i = 0; i < n; i++) begin
      cnt_en_n = !en_at(i, pat);
      @(negedge clk);
    end
    cnt_en_n = 1;
  endtask

  function automatic logic [12:0] flow(bit keep, logic [1:0] m2, logic [1:0] m1);
    return {8'h00, keep, m2, m1};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "addr", int'(addr), 0);
    chk("R1", "eob1_n", int'(eob1_n), 1);
    chk("R1", "eob2_n", int'(eob2_n), 1);
    chk("R1", "wr_inhibit", int'(wr_inhibit), 0);
    chk("R1", "flag_q", int'(flag_q), 0);
    chk("R2", "cmd_ready", int'(cmd_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk_on = 1;

    // R1/R9: default linear mode runs past end of buffer 1
    cur_tag = "R9";
    cmd(3'd3, 13'd5);
    run(7);
    chk("R9", "addr", int'(addr), 7);
    chk("R4", "eob1_n", int'(eob1_n), 0);

    // R3 wrap
    cur_tag = "R3";
    cmd(3'd1, 13'h1FFD);
    run(5);
    chk("R3", "addr wrap", int'(addr), 'h0002);

    // R2 command edge blocks counting; opcode 0 has no effect
    cur_tag = "R2";
    cmd(3'd1, 13'h0300);
    cmd(3'd5, 13'h1F00, 1);
    chk("R2", "addr held by cmd", int'(addr), 'h0300);
    cmd(3'd0, 13'h1FFF, 1);
    chk("R2", "addr after nop", int'(addr), 'h0300);

    // Sweep all mode pairs under three enable patterns
    for (int m2 = 0; m2 < 4; m2++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        for (int pat = 0; pat < 3; pat++) begin
          case (m1)
            0: cur_tag = "R5";
            1: cur_tag = "R6";
            2: cur_tag = "R9";
            default: cur_tag = "R10";
          endcase
          cmd(3'd2, 13'h020);
          cmd(3'd3, 13'h024);
          cmd(3'd4, 13'h040);
          cmd(3'd5, 13'h027);
          cmd(3'd6, flow(1, 2'(m2), 2'(m1)));
          cmd(3'd7, 13'd0);
          cmd(3'd1, 13'h020);
          run(22, pat);
          cur_tag = "R7";
          cmd(3'd6, flow(0, 2'(m2), 2'(m1)));
          run(6, pat);
        end
      end
    end

    // R5 equal end addresses, both chaining
    cur_tag = "R5";
    cmd(3'd2, 13'h030);
    cmd(3'd3, 13'h034);
    cmd(3'd4, 13'h050);
    cmd(3'd5, 13'h034);
    cmd(3'd6, flow(1, 2'b00, 2'b00));
    cmd(3'd7, 13'd0);
    cmd(3'd1, 13'h031);
    run(3);
    chk("R5", "addr at end", int'(addr), 'h034);
    chk("R5", "both flags", int'(flag_q), 3);
    run(1);
    chk("R5", "jump to start1", int'(addr), 'h030);

    // R11 flag write
    cur_tag = "R11";
    cmd(3'd7, 13'd2);
    chk("R11", "clear bit0", int'(flag_q), 2);
    cmd(3'd7, 13'd3);
    chk("R11", "keep", int'(flag_q), 2);
    cmd(3'd7, 13'd0);
    chk("R11", "clear all", int'(flag_q), 0);

    // R6 halt at end+1, R7 release to end+2
    cur_tag = "R6";
    cmd(3'd2, 13'h100);
    cmd(3'd3, 13'h104);
    cmd(3'd5, 13'h1F00);
    cmd(3'd6, flow(1, 2'b10, 2'b01));
    cmd(3'd1, 13'h100);
    run(5);
    chk("R6", "halt end+1", int'(addr), 'h105);
    chk("R6", "inhibit", int'(wr_inhibit), 1);
    run(3);
    chk("R6", "held", int'(addr), 'h105);
    cur_tag = "R7";
    cmd(3'd6, flow(0, 2'b10, 2'b01));
    run(1);
    chk("R7", "end+2", int'(addr), 'h106);
    chk("R7", "inhibit off", int'(wr_inhibit), 0);

    // R6 halt at end when enable is high; R7 release needs an enabled next edge
    cur_tag = "R6";
    cmd(3'd1, 13'h100);
    run(4);
    cnt_en_n = 1; @(negedge clk);
    chk("R6", "halt at end", int'(addr), 'h104);
    chk("R6", "inhibit", int'(wr_inhibit), 1);
    run(2);
    chk("R6", "held at end", int'(addr), 'h104);
    cur_tag = "R7";
    cmd(3'd6, flow(0, 2'b10, 2'b01));
    cnt_en_n = 1; @(negedge clk);
    run(1);
    chk("R7", "missed release", int'(addr), 'h104);
    chk("R7", "still inhibited", int'(wr_inhibit), 1);
    cmd(3'd6, flow(0, 2'b10, 2'b01));
    run(1);
    chk("R7", "released", int'(addr), 'h105);
    chk("R7", "inhibit off", int'(wr_inhibit), 0);

    // R8 release by start load and pointer load
    cur_tag = "R8";
    cmd(3'd1, 13'h100);
    run(5);
    cmd(3'd4, 13'h040);
    chk("R8", "start2 releases", int'(wr_inhibit), 0);
    run(1);
    chk("R8", "moves", int'(addr), 'h106);
    cmd(3'd1, 13'h100);
    run(5);
    cmd(3'd2, 13'h100);
    chk("R8", "start1 releases", int'(wr_inhibit), 0);
    run(5);
    cmd(3'd1, 13'h200);
    chk("R8", "ptr load", int'(addr), 'h200);
    chk("R8", "ptr releases", int'(wr_inhibit), 0);

    // R10 mask keeps eob high with flag set
    cur_tag = "R10";
    cmd(3'd6, flow(1, 2'b10, 2'b11));
    cmd(3'd7, 13'd0);
    cmd(3'd1, 13'h102);
    run(4);
    chk("R10", "flag", int'(flag_q[0]), 1);
    chk("R10", "eob1_n high", int'(eob1_n), 1);
    chk("R10", "continues", int'(addr), 'h106);

    @(negedge clk);
    finish_run();
  end
endmodule